// File: doc/BRIEF.md
# Multi-instance status register bank

This block keeps the status-reporting state of an instrument that several host links can talk to at once. For every link it holds a latched trip-event register, a latched standard event register, a live view of the power-stage state, and five masks. The masks select which bits feed the status-byte summaries, which summaries raise a service request, and which status-byte bits drive the parallel-poll `ist` flag. Each link has its own copy of the latched registers. A query that clears a register on one link therefore never takes away events that another link has not read yet.

Protection events (hardware fault, over-current, over-voltage, over-power) arrive as single-cycle pulses that every instance sees. Command, execution, query and device errors arrive as pulses on a separate input for each instance. Each instance has a 3-bit address, a read strobe and a write strobe. A read returns its data one cycle later on that instance's data output. Reading a latched register clears it. The status byte, the service-request flag and `ist` are registered outputs that are recomputed on every clock.

Register addresses: 0 trip events (read-only, clear-on-read), 1 trip mask, 2 live state (read-only), 3 state mask, 4 standard events (read-only, clear-on-read), 5 standard-event mask, 6 service-request mask, 7 parallel-poll mask.

Top module: `status_bank`

## Requirements
- R1: A trip pulse sets a bit in the trip register (address 0) of every instance: fault sets bit 7, over-current bit 2, over-voltage bit 1, over-power bit 0. Bits stay set until read, and bits 6..3 always read 0.
- R2: A read of address 0 puts the register value on `rdata_o` one cycle later and clears the register. An event pulse in the same cycle as that read stays set and is returned by the next read.
- R3: Per-instance error pulses set standard-event bits: query error bit 2, device error bit 3, execution error bit 4, command error bit 5. Reading address 4 returns and clears the register, and a coincident pulse wins over the clear. Bits 7, 6, 1 and 0 read 0.
- R4: A read of address 2 returns the value `state_i` had in the read cycle. It is not latched.
- R5: Writes to addresses 1, 3, 5, 6 and 7 store `wdata_i` and read back unchanged. Writes to addresses 0, 2 and 4 have no effect. A read and a write in the same cycle return the old value. `rdata_o` holds its value when no read occurs.
- R6: Status byte bit 0 is the OR of (trip AND trip mask). Bit 1 is the OR of (state AND state mask). Bit 5 is the OR of (standard events AND their mask). Bits 2, 3, 4 and 7 are 0. The byte appears one cycle after the register values it is computed from.
- R7: Status byte bit 6 and `srq_o` equal the OR of (summary bits AND the service-request mask), with the same one-cycle lag.
- R8: `ist_o` equals the OR of (full status byte, bit 6 included, AND the parallel-poll mask), with the same one-cycle lag.
- R9: Reads, clears and writes on one instance leave every other instance's registers unchanged.
- R10: A synchronous reset clears all registers, masks, read data and status outputs in every instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_fault_i | input | 1 | Hardware fault trip pulse |
| trip_ocp_i | input | 1 | Over-current trip pulse |
| trip_ovp_i | input | 1 | Over-voltage trip pulse |
| trip_opp_i | input | 1 | Over-power trip pulse |
| cmd_err_i | input | NUM_INST | Command error pulse per instance |
| exe_err_i | input | NUM_INST | Execution error pulse per instance |
| qry_err_i | input | NUM_INST | Query error pulse per instance |
| dev_err_i | input | NUM_INST | Device error pulse per instance |
| state_i | input | 8 | Live power-stage state |
| rd_i | input | NUM_INST | Read strobe per instance |
| wr_i | input | NUM_INST | Write strobe per instance |
| addr_i | input | NUM_INST*3 | Register address per instance |
| wdata_i | input | NUM_INST*8 | Write data per instance |
| rdata_o | output | NUM_INST*8 | Registered read data per instance |
| stb_o | output | NUM_INST*8 | Status byte per instance |
| srq_o | output | NUM_INST | Service request per instance |
| ist_o | output | NUM_INST | Parallel-poll ist flag per instance |

## Verification
The bench aims at an event pulse that lands in the same cycle as the clearing read. A design that let the clear win would return zero on the next read and lose that trip for good. It also reads one instance twice and then reads the others. A shared register would show the others empty after the first instance cleared it. Writes to the read-only addresses are checked by reading those addresses back, which catches a decoder that lets a write corrupt a latched register. The status byte, `srq_o` and `ist_o` are compared on every clock against a model with a one-cycle lag. This exposes a summary built from the wrong mask, reserved bits that leak into the byte, or an `ist` that leaves out bit 6.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_TRIP     = 3'd0,
    A_TRIP_EN  = 3'd1,
    A_STATE    = 3'd2,
    A_STATE_EN = 3'd3,
    A_SEV      = 3'd4,
    A_SEV_EN   = 3'd5,
    A_SRQ_EN   = 3'd6,
    A_POLL_EN  = 3'd7
  } reg_addr_e;

  // trip register bit positions
  localparam int TRIP_FAULT_BIT = 7;
  localparam int TRIP_OCP_BIT   = 2;
  localparam int TRIP_OVP_BIT   = 1;
  localparam int TRIP_OPP_BIT   = 0;

  // standard event register bit positions
  localparam int SEV_QRY_BIT = 2;
  localparam int SEV_DEV_BIT = 3;
  localparam int SEV_EXE_BIT = 4;
  localparam int SEV_CMD_BIT = 5;

  // status byte bit positions
  localparam int STB_TRIP_BIT  = 0;
  localparam int STB_STATE_BIT = 1;
  localparam int STB_SEV_BIT   = 5;
  localparam int STB_RQS_BIT   = 6;

  localparam logic [REG_W-1:0] TRIP_LIVE_MASK = 8'h87;
  localparam logic [REG_W-1:0] SEV_LIVE_MASK  = 8'h3C;
endpackage

// File: rtl/stat_event_reg.sv
module stat_event_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  // a set in the clearing cycle survives the clear
  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= ((clr_i ? '0 : q_r) | set_i) & LIVE;
  end

  assign q_o = q_r;
endmodule

// File: rtl/stat_summary.sv
module stat_summary
  import stat_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] trip_i,
  input  logic [REG_W-1:0] trip_en_i,
  input  logic [REG_W-1:0] state_i,
  input  logic [REG_W-1:0] state_en_i,
  input  logic [REG_W-1:0] sev_i,
  input  logic [REG_W-1:0] sev_en_i,
  input  logic [REG_W-1:0] srq_en_i,
  input  logic [REG_W-1:0] poll_en_i,
  output logic [REG_W-1:0] stb_o,
  output logic             srq_o,
  output logic             ist_o
);
  logic [REG_W-1:0] base, full;
  logic             rqs;
  logic [REG_W-1:0] stb_q;
  logic             srq_q, ist_q;

  always_comb begin
    base                = '0;
    base[STB_TRIP_BIT]  = |(trip_i & trip_en_i);
    base[STB_STATE_BIT] = |(state_i & state_en_i);
    base[STB_SEV_BIT]   = |(sev_i & sev_en_i);
    rqs                 = |(base & srq_en_i);
    full                = base;
    full[STB_RQS_BIT]   = rqs;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= '0;
      srq_q <= 1'b0;
      ist_q <= 1'b0;
    end else begin
      stb_q <= full;
      srq_q <= rqs;
      ist_q <= |(full & poll_en_i);
    end
  end

  assign stb_o = stb_q;
  assign srq_o = srq_q;
  assign ist_o = ist_q;
endmodule

// File: rtl/stat_instance.sv
module stat_instance
  import stat_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  trip_set_i,
  input  logic [REG_W-1:0]  sev_set_i,
  input  logic [REG_W-1:0]  state_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  stb_o,
  output logic              srq_o,
  output logic              ist_o
);
  reg_addr_e        sel;
  logic [REG_W-1:0] trip_q, sev_q;
  logic [REG_W-1:0] trip_en_q, state_en_q, sev_en_q, srq_en_q, poll_en_q;
  logic [REG_W-1:0] rd_val, rdata_q;

  assign sel = reg_addr_e'(addr_i);

  stat_event_reg #(.W(REG_W), .LIVE(TRIP_LIVE_MASK)) u_trip (
    .clk(clk), .rst(rst), .set_i(trip_set_i),
    .clr_i(rd_i && sel == A_TRIP), .q_o(trip_q));

  stat_event_reg #(.W(REG_W), .LIVE(SEV_LIVE_MASK)) u_sev (
    .clk(clk), .rst(rst), .set_i(sev_set_i),
    .clr_i(rd_i && sel == A_SEV), .q_o(sev_q));

  // mask registers; read-only addresses fall through to default
  always_ff @(posedge clk) begin
    if (rst) begin
      trip_en_q  <= '0;
      state_en_q <= '0;
      sev_en_q   <= '0;
      srq_en_q   <= '0;
      poll_en_q  <= '0;
    end else if (wr_i) begin
      case (sel)
        A_TRIP_EN:  trip_en_q  <= wdata_i;
        A_STATE_EN: state_en_q <= wdata_i;
        A_SEV_EN:   sev_en_q   <= wdata_i;
        A_SRQ_EN:   srq_en_q   <= wdata_i;
        A_POLL_EN:  poll_en_q  <= wdata_i;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      A_TRIP:     rd_val = trip_q;
      A_TRIP_EN:  rd_val = trip_en_q;
      A_STATE:    rd_val = state_i;
      A_STATE_EN: rd_val = state_en_q;
      A_SEV:      rd_val = sev_q;
      A_SEV_EN:   rd_val = sev_en_q;
      A_SRQ_EN:   rd_val = srq_en_q;
      default:    rd_val = poll_en_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  stat_summary u_sum (
    .clk(clk), .rst(rst),
    .trip_i(trip_q), .trip_en_i(trip_en_q),
    .state_i(state_i), .state_en_i(state_en_q),
    .sev_i(sev_q), .sev_en_i(sev_en_q),
    .srq_en_i(srq_en_q), .poll_en_i(poll_en_q),
    .stb_o(stb_o), .srq_o(srq_o), .ist_o(ist_o));
endmodule

// File: rtl/status_bank.sv
module status_bank
  import stat_bank_pkg::*;
#(
  parameter int NUM_INST = 6,
  localparam int AW = NUM_INST * ADDR_W,
  localparam int DW = NUM_INST * REG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trip_fault_i,
  input  logic                trip_ocp_i,
  input  logic                trip_ovp_i,
  input  logic                trip_opp_i,
  input  logic [NUM_INST-1:0] cmd_err_i,
  input  logic [NUM_INST-1:0] exe_err_i,
  input  logic [NUM_INST-1:0] qry_err_i,
  input  logic [NUM_INST-1:0] dev_err_i,
  input  logic [REG_W-1:0]    state_i,
  input  logic [NUM_INST-1:0] rd_i,
  input  logic [NUM_INST-1:0] wr_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic [DW-1:0]       stb_o,
  output logic [NUM_INST-1:0] srq_o,
  output logic [NUM_INST-1:0] ist_o
);
  logic [REG_W-1:0] trip_set;

  always_comb begin
    trip_set                 = '0;
    trip_set[TRIP_FAULT_BIT] = trip_fault_i;
    trip_set[TRIP_OCP_BIT]   = trip_ocp_i;
    trip_set[TRIP_OVP_BIT]   = trip_ovp_i;
    trip_set[TRIP_OPP_BIT]   = trip_opp_i;
  end

  for (genvar g = 0; g < NUM_INST; g++) begin : g_inst
    logic [REG_W-1:0] sev_set;

    always_comb begin
      sev_set              = '0;
      sev_set[SEV_QRY_BIT] = qry_err_i[g];
      sev_set[SEV_DEV_BIT] = dev_err_i[g];
      sev_set[SEV_EXE_BIT] = exe_err_i[g];
      sev_set[SEV_CMD_BIT] = cmd_err_i[g];
    end

    stat_instance u_inst (
      .clk(clk), .rst(rst),
      .trip_set_i(trip_set), .sev_set_i(sev_set), .state_i(state_i),
      .rd_i(rd_i[g]), .wr_i(wr_i[g]),
      .addr_i(addr_i[g*ADDR_W +: ADDR_W]),
      .wdata_i(wdata_i[g*REG_W +: REG_W]),
      .rdata_o(rdata_o[g*REG_W +: REG_W]),
      .stb_o(stb_o[g*REG_W +: REG_W]),
      .srq_o(srq_o[g]), .ist_o(ist_o[g]));
  end
endmodule

// File: rtl/status_bank_chk.sv
module status_bank_chk #(
  parameter int NUM_INST = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  trip_fault_i,
  input logic                  trip_ocp_i,
  input logic                  trip_ovp_i,
  input logic                  trip_opp_i,
  input logic [NUM_INST-1:0]   rd_i,
  input logic [NUM_INST*3-1:0] addr_i,
  input logic [NUM_INST*8-1:0] rdata_o,
  input logic [NUM_INST*8-1:0] stb_o,
  input logic [NUM_INST-1:0]   srq_o,
  input logic [NUM_INST-1:0]   ist_o
);
  logic trip_any;
  assign trip_any = trip_fault_i | trip_ocp_i | trip_ovp_i | trip_opp_i;

  for (genvar g = 0; g < NUM_INST; g++) begin : g_chk
    // R1
    trip_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(rd_i[g]) && $past(addr_i[g*3 +: 3]) == 3'd0)
        |-> rdata_o[g*8+3 +: 4] == 4'd0);

    // R2
    trip_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (trip_opp_i && rd_i[g] && addr_i[g*3 +: 3] == 3'd0)
        ##1 (rd_i[g] && addr_i[g*3 +: 3] == 3'd0) |=> rdata_o[g*8]);

    // R2
    trip_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(rd_i[g]) && $past(addr_i[g*3 +: 3]) == 3'd0
        && !$past(trip_any) && rd_i[g] && addr_i[g*3 +: 3] == 3'd0)
        |=> rdata_o[g*8 +: 8] == 8'd0);

    // R3
    sev_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(rd_i[g]) && $past(addr_i[g*3 +: 3]) == 3'd4)
        |-> (rdata_o[g*8 +: 8] & 8'hC3) == 8'd0);

    // R6
    stb_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (stb_o[g*8 +: 8] & 8'h9C) == 8'd0);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (stb_o[g*8 +: 8] == 8'd0 && rdata_o[g*8 +: 8] == 8'd0
                      && !srq_o[g] && !ist_o[g]));
  end
endmodule

bind status_bank status_bank_chk #(.NUM_INST(NUM_INST)) chk_i (
  .clk(clk), .rst(rst),
  .trip_fault_i(trip_fault_i), .trip_ocp_i(trip_ocp_i),
  .trip_ovp_i(trip_ovp_i), .trip_opp_i(trip_opp_i),
  .rd_i(rd_i), .addr_i(addr_i), .rdata_o(rdata_o),
  .stb_o(stb_o), .srq_o(srq_o), .ist_o(ist_o));

// File: tb/status_bank_tb_top.sv
`timescale 1ns/1ps
module status_bank_tb_top;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fault = 0, ocp = 0, ovp = 0, opp = 0;
  logic [N-1:0] cmd = '0, exe = '0, qry = '0, dev = '0, rd = '0, wr = '0;
  logic [7:0] state = '0;
  logic [N*3-1:0] addr = '0;
  logic [N*8-1:0] wdata = '0;
  logic [N*8-1:0] rdata, stb;
  logic [N-1:0] srq, ist;

  always #2 clk = ~clk;

  status_bank #(.NUM_INST(N)) dut_i (
    .clk(clk), .rst(rst),
    .trip_fault_i(fault), .trip_ocp_i(ocp), .trip_ovp_i(ovp), .trip_opp_i(opp),
    .cmd_err_i(cmd), .exe_err_i(exe), .qry_err_i(qry), .dev_err_i(dev),
    .state_i(state), .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .stb_o(stb), .srq_o(srq), .ist_o(ist));

  // reference state
  logic [7:0] m_trip [N], m_sev [N], m_ten [N], m_sten [N], m_seven [N];
  logic [7:0] m_sre [N], m_ppe [N], m_rdata [N], m_stb [N];
  logic       m_srq [N], m_ist [N];
  string      m_rtag [N];
  int vectors = 0, miscompares = 0;
  bit done = 0;
  string phase = "";

  task automatic chk(string tag, string what, int i, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s inst %0d: actual %02h expected %02h", tag, what, i, act, exp);
    end
  endtask

  function automatic string addr_tag(int a);
    case (a)
      0: return "R1";
      2: return "R4";
      4: return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic model_step();
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        m_trip[i] = 0; m_sev[i] = 0; m_ten[i] = 0; m_sten[i] = 0; m_seven[i] = 0;
        m_sre[i] = 0; m_ppe[i] = 0; m_rdata[i] = 0; m_stb[i] = 0;
        m_srq[i] = 0; m_ist[i] = 0; m_rtag[i] = "R10";
      end else begin
        int a = int'(addr[i*3 +: 3]);
        logic [7:0] b, tset, sset;
        logic rq;
        if (rd[i]) begin
          case (a)
            0: m_rdata[i] = m_trip[i];
            1: m_rdata[i] = m_ten[i];
            2: m_rdata[i] = state;
            3: m_rdata[i] = m_sten[i];
            4: m_rdata[i] = m_sev[i];
            5: m_rdata[i] = m_seven[i];
            6: m_rdata[i] = m_sre[i];
            default: m_rdata[i] = m_ppe[i];
          endcase
          m_rtag[i] = (phase != "") ? phase : addr_tag(a);
        end
        b = 8'h00;
        b[0] = |(m_trip[i] & m_ten[i]);
        b[1] = |(state & m_sten[i]);
        b[5] = |(m_sev[i] & m_seven[i]);
        rq = |(b & m_sre[i]);
        b[6] = rq;
        m_stb[i] = b;
        m_srq[i] = rq;
        m_ist[i] = |(b & m_ppe[i]);
        tset = {fault, 4'b0, ocp, ovp, opp};
        sset = {2'b0, cmd[i], exe[i], dev[i], qry[i], 2'b0};
        m_trip[i] = ((rd[i] && a == 0) ? 8'h00 : m_trip[i]) | tset;
        m_sev[i]  = ((rd[i] && a == 4) ? 8'h00 : m_sev[i]) | sset;
        if (wr[i]) begin
          case (a)
            1: m_ten[i]   = wdata[i*8 +: 8];
            3: m_sten[i]  = wdata[i*8 +: 8];
            5: m_seven[i] = wdata[i*8 +: 8];
            6: m_sre[i]   = wdata[i*8 +: 8];
            7: m_ppe[i]   = wdata[i*8 +: 8];
            default: ;
          endcase
        end
      end
    end
  endtask

  task automatic compare();
    for (int i = 0; i < N; i++) begin
      string t = rst ? "R10" : "";
      chk(rst ? t : m_rtag[i], "rdata", i, rdata[i*8 +: 8], m_rdata[i]);
      chk(rst ? t : "R6", "stb", i, stb[i*8 +: 8], m_stb[i]);
      chk(rst ? t : "R7", "srq", i, {7'b0, srq[i]}, {7'b0, m_srq[i]});
      chk(rst ? t : "R8", "ist", i, {7'b0, ist[i]}, {7'b0, m_ist[i]});
    end
  endtask

  task automatic tick(string tag);
    phase = tag;
    @(negedge clk);
    model_step();
    compare();
    fault = 0; ocp = 0; ovp = 0; opp = 0;
    cmd = '0; exe = '0; qry = '0; dev = '0; rd = '0; wr = '0;
  endtask

  task automatic acc(int i, bit r, bit w, int a, logic [7:0] d);
    rd[i] = r; wr[i] = w;
    addr[i*3 +: 3] = 3'(a);
    wdata[i*8 +: 8] = d;
  endtask

  initial begin
    // R10: reset state
    repeat (3) tick("R10");
    rst = 0;
    tick("R10");
    // R1: pulses latch in all instances
    fault = 1; opp = 1; tick("R1");
    tick("R1");
    acc(3, 1, 0, 0, 0); tick("R1");
    // R2: event coincident with clearing read survives
    acc(3, 1, 0, 0, 0); ocp = 1; tick("R2");
    acc(3, 1, 0, 0, 0); tick("R2");
    acc(3, 1, 0, 0, 0); tick("R2");
    tick("R2");
    // R9: clearing instance 0 leaves instance 5 intact
    ovp = 1; tick("R9");
    acc(0, 1, 0, 0, 0); tick("R9");
    acc(0, 1, 0, 0, 0); tick("R9");
    acc(5, 1, 0, 0, 0); acc(4, 1, 0, 4, 0); tick("R9");
    // R3: standard events, coincident set wins
    cmd[1] = 1; qry[1] = 1; tick("R3");
    acc(1, 1, 0, 4, 0); dev[1] = 1; tick("R3");
    acc(1, 1, 0, 4, 0); tick("R3");
    acc(1, 1, 0, 4, 0); tick("R3");
    // R5: writes to read-only addresses ignored, masks read back
    exe[1] = 1; tick("R5");
    acc(1, 0, 1, 0, 8'hFF); tick("R5");
    acc(1, 0, 1, 4, 8'hFF); tick("R5");
    acc(1, 0, 1, 2, 8'hFF); tick("R5");
    acc(1, 1, 0, 4, 0); tick("R5");
    acc(1, 1, 0, 0, 0); tick("R5");
    for (int a = 1; a < 8; a += 2) begin
      acc(1, 1, 1, a, 8'(8'h5A + a)); tick("R5");
      acc(1, 1, 0, a, 0); tick("R5");
    end
    acc(1, 1, 1, 6, 8'hC3); tick("R5");
    acc(1, 1, 0, 6, 0); tick("R5");
    // R4: live state
    state = 8'hA5; acc(2, 1, 0, 2, 0); tick("R4");
    state = 8'h3C; acc(2, 1, 0, 2, 0); tick("R4");
    // R6 R7 R8: summaries through masks
    acc(2, 0, 1, 1, 8'h04); tick("R6");
    acc(2, 0, 1, 6, 8'h01); tick("R7");
    acc(2, 0, 1, 7, 8'h40); tick("R8");
    ocp = 1; tick("R6");
    repeat (3) tick("R7");
    acc(2, 1, 0, 0, 0); tick("R8");
    repeat (2) tick("R8");
    // random traffic
    for (int c = 0; c < 2500; c++) begin
      fault = ($urandom_range(0, 15) == 0);
      ocp   = ($urandom_range(0, 15) == 0);
      ovp   = ($urandom_range(0, 15) == 0);
      opp   = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 7) == 0) state = 8'($urandom);
      for (int i = 0; i < N; i++) begin
        cmd[i] = ($urandom_range(0, 11) == 0);
        exe[i] = ($urandom_range(0, 11) == 0);
        qry[i] = ($urandom_range(0, 11) == 0);
        dev[i] = ($urandom_range(0, 11) == 0);
        acc(i, $urandom_range(0, 2) == 0, $urandom_range(0, 4) == 0,
            $urandom_range(0, 7), 8'($urandom));
      end
      tick("");
    end
    // R10: reset mid-run
    rst = 1; tick("R10"); tick("R10");
    rst = 0;
    for (int i = 0; i < N; i++) acc(i, 1, 0, 6, 0);
    tick("R10");
    tick("R10");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule